// File: doc/BRIEF.md
# Bit-Serial Hash Message Padder

This block prepares a message for a 512-bit block hash compression stage. A caller first presents the message length in bits together with a one-cycle load strobe. It then streams the message as 32-bit words through a valid/ready handshake. The block moves one message bit per clock into a 512-bit block register. When the message runs out, it appends a single 1 bit and zero fill up to position 256 of a block. The last 256 bits carry the message length, so the padded stream is always a whole number of 512-bit blocks.

Each completed block is offered on a valid/ready output. The block that carries the length field is marked as the final one. Three separate events drive the block: the block register filling, the current word running out of bits, and the message ending. Each event is handled in its own place, so none of them depends on the others' sizes. When the output consumer stalls, the bit stream stops and no new word is taken until the held block is accepted.

Top module: `msg_pad512`

## Requirements
- R1: After reset, out_valid and in_ready are both low.
- R2: Message bits enter the stream in order, one per clock at most. Each word is read from bit 31 down to bit 0. The first stream bit of every block appears at out_block[511] and the last at out_block[0].
- R3: A word is taken only in a cycle where in_valid and in_ready are both high. Exactly ceil(L/32) words are taken for an L-bit message. A partial final word contributes only its top L mod 32 bits.
- R4: Directly after the last message bit comes a single 1 bit. It is followed by 0 bits until the position within the block reaches 256.
- R5: The last 256 bits of the padded stream hold the 64-bit value of len_bits, zero-extended to 256 bits and sent most-significant bit first. out_last is high exactly with the block carrying this field.
- R6: If an L-bit message has L mod 512 of 256 or more, the 1 bit and zeros finish the current block, and one more block follows, holding zeros and then the length field. The total block count is ceil((L+257)/512), and only the final block has out_last high.
- R7: A zero-length message yields exactly one block: bit 511 set, all other bits zero, out_last high.
- R8: While out_valid is high and out_ready is low, out_block and out_valid hold their values and in_ready stays low.
- R9: After the final block is accepted, the block is idle: out_valid and in_ready stay low until the next len_load. A len_load pulse during a message is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_load | input | 1 | One-cycle strobe that starts a message (taken only when idle) |
| len_bits | input | 64 | Message length in bits, sampled with len_load |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Message word, first bit at bit 31 |
| in_ready | output | 1 | Padder can take a word this cycle |
| out_ready | input | 1 | Consumer accepts the offered block |
| out_valid | output | 1 | A completed 512-bit block is offered |
| out_block | output | 512 | Block contents, first stream bit at bit 511 |
| out_last | output | 1 | Offered block is the final one of the message |

## Verification
The assertions assume that a new len_load arrives only after the final block of the previous message has been accepted. Otherwise the idle check after the last block would not hold. The bench keeps to this: it pulses a genuine length load only between messages. It drives spurious len_load pulses only while message words are still outstanding, when the padder is certain to be inside the message phase. Random out_ready duty cycles, including a heavily throttled one, put the hold and stall behaviour under load. Directed lengths sit on the word and block boundaries around positions 0, 256 and 512.

// File: rtl/msg_pad_pkg.sv
package msg_pad_pkg;

    localparam int WORD_W = 32;
    localparam int BLK_W  = 512;
    localparam int LEN_W  = 64;
    localparam int LFLD_W = 256;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MSG,
        PH_MARK,
        PH_FILL,
        PH_LEN
    } phase_t;

    // One bit-shift command from the controller to the block register.
    typedef struct packed {
        logic shift;
        logic bit_val;
        logic last;
    } bitcmd_t;

endpackage

// File: rtl/word_feeder.sv
module word_feeder #(
    parameter int WORD_W = msg_pad_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              take,
    input  logic              flush,
    output logic              have,
    output logic              bit_o
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            idx  <= '0;
            have <= 1'b0;
        end else if (load) begin
            sh   <= word;
            idx  <= '0;
            have <= 1'b1;
        end else if (take) begin
            sh  <= {sh[WORD_W-2:0], 1'b0};
            idx <= idx + 1'b1;
            if (idx == IDX_END || flush)
                have <= 1'b0;
        end
    end

    assign bit_o = sh[WORD_W-1];
endmodule

// File: rtl/block_shifter.sv
module block_shifter #(
    parameter int BLK_W = msg_pad_pkg::BLK_W,
    localparam int POS_W = $clog2(BLK_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  msg_pad_pkg::bitcmd_t cmd,
    input  logic                 out_ready,
    output logic                 go,
    output logic [POS_W-1:0]     pos,
    output logic                 out_valid,
    output logic [BLK_W-1:0]     out_block,
    output logic                 out_last
);
    localparam logic [POS_W-1:0] POS_END = POS_W'(BLK_W - 1);

    logic [BLK_W-1:0] acc;
    logic [BLK_W-1:0] acc_next;
    logic             full_now;

    assign go       = !out_valid || out_ready;
    assign acc_next = {acc[BLK_W-2:0], cmd.bit_val};
    assign full_now = cmd.shift && (pos == POS_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            pos       <= '0;
            out_valid <= 1'b0;
            out_block <= '0;
            out_last  <= 1'b0;
        end else begin
            if (cmd.shift) begin
                acc <= acc_next;
                pos <= full_now ? '0 : pos + 1'b1;
            end
            if (full_now) begin
                out_block <= acc_next;
                out_valid <= 1'b1;
                out_last  <= cmd.last;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl #(
    parameter int LEN_W  = msg_pad_pkg::LEN_W,
    parameter int LFLD_W = msg_pad_pkg::LFLD_W,
    parameter int BLK_W  = msg_pad_pkg::BLK_W,
    localparam int POS_W = $clog2(BLK_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 len_load,
    input  logic [LEN_W-1:0]     len_bits,
    input  logic                 go,
    input  logic [POS_W-1:0]     pos,
    input  logic                 have,
    input  logic                 wbit,
    output msg_pad_pkg::bitcmd_t cmd,
    output logic                 in_ready,
    output logic                 flush
);
    import msg_pad_pkg::*;

    localparam logic [POS_W-1:0] POS_END   = POS_W'(BLK_W - 1);
    localparam logic [POS_W-1:0] POS_LSTRT = POS_W'(BLK_W - LFLD_W);

    phase_t            phase;
    logic [LEN_W-1:0]  rem;
    logic [LFLD_W-1:0] lsh;

    always_comb begin
        cmd      = '0;
        in_ready = 1'b0;
        flush    = 1'b0;
        unique case (phase)
            PH_MSG: begin
                in_ready    = go && !have && (rem != '0);
                cmd.shift   = go && have;
                cmd.bit_val = wbit;
                flush       = (rem == LEN_W'(1));
            end
            PH_MARK: begin
                cmd.shift   = go;
                cmd.bit_val = 1'b1;
            end
            PH_FILL: begin
                cmd.shift   = go && (pos != POS_LSTRT);
            end
            PH_LEN: begin
                cmd.shift   = go;
                cmd.bit_val = lsh[LFLD_W-1];
                cmd.last    = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rem   <= '0;
            lsh   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (len_load) begin
                    rem   <= len_bits;
                    lsh   <= {{(LFLD_W-LEN_W){1'b0}}, len_bits};
                    phase <= PH_MSG;
                end
                PH_MSG: begin
                    if (cmd.shift)
                        rem <= rem - 1'b1;
                    if (rem == '0)
                        phase <= PH_MARK;
                end
                PH_MARK: if (go) phase <= PH_FILL;
                PH_FILL: if (go && pos == POS_LSTRT) phase <= PH_LEN;
                PH_LEN: if (go) begin
                    lsh <= {lsh[LFLD_W-2:0], 1'b0};
                    if (pos == POS_END)
                        phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msg_pad512.sv
module msg_pad512 #(
    parameter int WORD_W = msg_pad_pkg::WORD_W,
    parameter int BLK_W  = msg_pad_pkg::BLK_W,
    parameter int LEN_W  = msg_pad_pkg::LEN_W,
    parameter int LFLD_W = msg_pad_pkg::LFLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_load,
    input  logic [LEN_W-1:0]  len_bits,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_block,
    output logic              out_last
);
    localparam int POS_W = $clog2(BLK_W);

    msg_pad_pkg::bitcmd_t cmd;
    logic             go;
    logic [POS_W-1:0] pos;
    logic             have;
    logic             wbit;
    logic             flush;

    word_feeder #(.WORD_W(WORD_W)) u_feed (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid && in_ready),
        .word  (in_word),
        .take  (cmd.shift && have),
        .flush (flush),
        .have  (have),
        .bit_o (wbit)
    );

    pad_ctrl #(.LEN_W(LEN_W), .LFLD_W(LFLD_W), .BLK_W(BLK_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .len_load (len_load),
        .len_bits (len_bits),
        .go       (go),
        .pos      (pos),
        .have     (have),
        .wbit     (wbit),
        .cmd      (cmd),
        .in_ready (in_ready),
        .flush    (flush)
    );

    block_shifter #(.BLK_W(BLK_W)) u_blk (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .out_ready (out_ready),
        .go        (go),
        .pos       (pos),
        .out_valid (out_valid),
        .out_block (out_block),
        .out_last  (out_last)
    );
endmodule

// File: rtl/msg_pad_chk.sv
module msg_pad_chk #(
    parameter int BLK_W = msg_pad_pkg::BLK_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [BLK_W-1:0] out_block
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !in_ready));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));

    // R8
    stall_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready));
endmodule

bind msg_pad512 msg_pad_chk #(.BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_block (out_block)
);

// File: tb/tb_msg_pad512.sv
module tb_msg_pad512;
    localparam int MAXW = 128;

    logic         clk = 1'b0;
    logic         rst;
    logic         len_load;
    logic [63:0]  len_bits;
    logic         in_valid;
    logic [31:0]  in_word;
    logic         in_ready;
    logic         out_ready;
    logic         out_valid;
    logic [511:0] out_block;
    logic         out_last;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] msg_w [MAXW];

    always #5 clk = ~clk;

    msg_pad512 dut (
        .clk(clk), .rst(rst), .len_load(len_load), .len_bits(len_bits),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_block(out_block), .out_last(out_last)
    );

    function automatic logic exp_bit(int k, int len, int total);
        logic [255:0] lf;
        lf = 256'(unsigned'(len));
        if (k < len) return msg_w[k / 32][31 - (k % 32)];
        if (k == len) return 1'b1;
        if (k >= total - 256) return lf[255 - (k - (total - 256))];
        return 1'b0;
    endfunction

    function automatic logic [511:0] exp_blk(int b, int len, int total);
        logic [511:0] r;
        for (int j = 0; j < 512; j++)
            r[511 - j] = exp_bit(b * 512 + j, len, total);
        return r;
    endfunction

    task automatic check(bit ok, string tag, string what,
                         logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_msg(int len, int rdy_pct, bit noise, string tag);
        int nw    = (len + 31) / 32;
        int total = ((len + 257 + 511) / 512) * 512;
        int nblk  = total / 512;
        int widx  = 0;
        int bidx  = 0;
        int cyc   = 0;
        bit got_last = 1'b0;
        for (int i = 0; i < nw; i++) msg_w[i] = $urandom;
        @(negedge clk);
        len_bits = 64'(len); len_load = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        len_load = 1'b0;
        while (!got_last && cyc < 40000) begin
            out_ready = (($urandom % 100) < rdy_pct);
            in_valid  = (widx < nw) && (($urandom % 4) != 0);
            in_word   = (widx < nw) ? msg_w[widx] : $urandom;
            // R9: stray length loads while words are still owed must be ignored
            len_load  = noise && (widx < nw) && (($urandom % 8) == 0);
            if (len_load) len_bits = {$urandom, $urandom};
            #1;
            if (out_valid && !out_ready)
                check(!in_ready, "R8", "in_ready during stall", 512'(in_ready), 512'(0));
            if (in_valid && in_ready) widx++;
            if (out_valid && out_ready) begin
                check(out_block == exp_blk(bidx, len, total), tag,
                      $sformatf("len %0d block %0d", len, bidx),
                      out_block, exp_blk(bidx, len, total));
                check(out_last == (bidx == nblk - 1), "R5",
                      $sformatf("last flag len %0d block %0d", len, bidx),
                      512'(out_last), 512'(bidx == nblk - 1));
                if (out_last) got_last = 1'b1;
                bidx++;
            end
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0; out_ready = 1'b0; len_load = 1'b0;
        #1;
        check(cyc < 40000, tag, "message timeout", 512'(cyc), 512'(40000));
        check(bidx == nblk, "R6", $sformatf("block count len %0d", len),
              512'(bidx), 512'(nblk));
        check(widx == nw, "R3", $sformatf("words taken len %0d", len),
              512'(widx), 512'(nw));
        check(!out_valid && !in_ready, "R9", "idle after message",
              512'({out_valid, in_ready}), 512'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        rst = 1'b1; len_load = 1'b0; len_bits = '0;
        in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!out_valid && !in_ready, "R1", "reset state",
              512'({out_valid, in_ready}), 512'(0));

        run_msg(0,   100, 1'b0, "R7");
        run_msg(0,   40,  1'b0, "R7");
        run_msg(1,   80,  1'b0, "R4");
        run_msg(31,  80,  1'b0, "R3");
        run_msg(32,  80,  1'b0, "R3");
        run_msg(33,  80,  1'b1, "R3");
        run_msg(255, 70,  1'b0, "R4");
        run_msg(256, 70,  1'b0, "R6");
        run_msg(511, 70,  1'b1, "R6");
        run_msg(512, 70,  1'b0, "R2");
        run_msg(767, 60,  1'b0, "R6");
        run_msg(768, 10,  1'b0, "R8");
        for (int i = 0; i < 12; i++)
            run_msg(int'($urandom % 3000), 30 + int'($urandom % 71),
                    1'(i % 2), "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule